// File: doc/BRIEF.md
# 22 kHz Signalling Tone Gate and Presence Detector

This block keys a 22 kHz square-wave tone enable for a supply-line signalling link and recovers a presence signal from a received tone. The transmit half divides the system clock to a half-period count, so it gives a square wave with equal high and low halves. The tone is gated by a force bit that keeps the tone running without a break, or by a data input that keys it on and off. A power-enable input silences it. Keying off during a high half lets that half finish, so the line never carries a shortened pulse.

The receive half takes a comparator-squared version of the line tone. It brings the signal into the clock domain and times the gap between successive rising edges. It pulls an active-low presence output low once two successive periods fall inside the accepted window. Presence is released when an out-of-window period is seen, or when no rising edge arrives for two nominal tone periods. Framing of the keyed data is left to firmware.

Top module: `tone22_gate`

## Requirements
- R1: After reset `tone_o` is 0 and `det_n_o` is 1.
- R2: Each high half and each low half of the tone lasts HALF = (CLK_HZ + TONE_HZ) / (2*TONE_HZ) clock cycles, which gives a 50% duty cycle. HALF is 50 at 2.2 MHz and 22 kHz.
- R3: With `en_i`=1 and `tone_force_i`=1 the tone runs without a break, and `key_i` has no effect on it.
- R4: With `tone_force_i`=0 the tone runs only while `key_i` is 1. From idle, `tone_o` goes high on the first clock edge that samples the request, and it starts with a full high half.
- R5: If the request is dropped during a high half, that half completes at full length and `tone_o` then stays low. If it is dropped during a low half, `tone_o` stays low and a new request restarts at once.
- R6: While `en_i` is 0, `tone_o` is 0 from the clock edge that samples it, whatever the force bit and key input are.
- R7: `det_n_o` goes low 3 cycles after the third rising edge of `det_in_i` that follows an idle line. The delay is two synchroniser stages plus the decision register. The first edge after idle measures no period, and the next two edges give two in-window periods.
- R8: The accepted period window is MIN_P = ceil(CLK_HZ/24000) to MAX_P = floor(CLK_HZ/18000) cycles, bounds included. At 2.2 MHz, periods of 92 and 122 cycles are accepted and periods of 91 and 123 are rejected.
- R9: A rising edge that ends an out-of-window period sets `det_n_o` high 3 cycles after that edge, even while presence is held.
- R10: When no rising edge arrives for TIMEOUT = 2*round(CLK_HZ/TONE_HZ) cycles, `det_n_o` returns high exactly TIMEOUT cycles after it last went low on an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Power enable; 0 silences the tone |
| tone_force_i | input | 1 | 1 = tone runs without a break, key input ignored |
| key_i | input | 1 | Data keying input used when the force bit is 0 |
| det_in_i | input | 1 | Comparator-squared received tone (asynchronous) |
| tone_o | output | 1 | 22 kHz tone enable square wave |
| det_n_o | output | 1 | Active-low tone presence |

## Verification
`tone_o` answers an input change one cycle later. After that, each of its transitions falls a fixed multiple of HALF cycles from the start of the tone. `det_n_o` reacts three cycles after a rising edge of `det_in_i`, and its release on timeout comes exactly TIMEOUT cycles after the edge that made it go low. The driver therefore records every expected level against an absolute cycle number at the moment it applies the stimulus. The monitor compares each item at the falling edge of that cycle, which places every check on the exact cycle where the result is due, with no polling window.

// File: rtl/tone22_pkg.sv
package tone22_pkg;

    // Half-period length in clock cycles, rounded to nearest
    function automatic int half_cycles(input int clk_hz, input int tone_hz);
        return (clk_hz + tone_hz) / (2 * tone_hz);
    endfunction

    // Full nominal period in cycles, rounded to nearest
    function automatic int period_cycles(input int clk_hz, input int tone_hz);
        return (clk_hz + tone_hz / 2) / tone_hz;
    endfunction

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_HIGH = 2'd1,
        GATE_LOW  = 2'd2
    } gate_state_e;

    // One receive-side observation per cycle
    typedef struct packed {
        logic hit;       // rising edge seen this cycle
        logic in_win;    // elapsed gap lies inside the accepted window
        logic at_limit;  // gap counter saturated (silence)
    } meas_t;

endpackage

// File: rtl/tone_half_timer.sv
module tone_half_timer #(
    parameter int HALF = 1136,
    localparam int CW  = $clog2(HALF + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;

    assign done_o = (cnt_q == CW'(HALF - 1));
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i || done_o) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(HALF))
        else $error("half timer out of range");
endmodule

// File: rtl/tone_gate_fsm.sv
module tone_gate_fsm
    import tone22_pkg::*;
#(
    parameter int HALF = 1136,
    localparam int CW  = $clog2(HALF + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          force_i,
    input  logic          key_i,
    input  logic [CW-1:0] t_cnt_i,
    input  logic          t_done_i,
    output logic          t_clr_o,
    output logic          tone_o
);
    gate_state_e state_q, state_d;
    logic        req;

    assign req     = force_i | key_i;
    assign t_clr_o = (state_q == GATE_IDLE);
    assign tone_o  = (state_q == GATE_HIGH);

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = GATE_IDLE;
        end else begin
            unique case (state_q)
                GATE_IDLE: if (req) state_d = GATE_HIGH;
                GATE_HIGH: if (t_done_i) state_d = req ? GATE_LOW : GATE_IDLE;
                GATE_LOW: begin
                    if (!req)          state_d = GATE_IDLE;
                    else if (t_done_i) state_d = GATE_HIGH;
                end
                default:   state_d = GATE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_IDLE;
        else     state_q <= state_d;
    end

    // R6
    en_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !tone_o)
        else $error("tone active while disabled");

    // R4
    gate_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_IDLE && en_i && (force_i || key_i)) |=> tone_o)
        else $error("tone did not start on request");

    // R5
    half_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(tone_o) && $past(en_i)) |-> ($past(t_cnt_i) == CW'(HALF - 1)))
        else $error("high half cut short");
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic rise_o
);
    logic [STAGES-1:0] pipe_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
            last_q <= 1'b0;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            last_q <= pipe_q[STAGES-1];
        end
    end

    assign rise_o = pipe_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tone_detector.sv
module tone_detector
    import tone22_pkg::*;
#(
    parameter int MIN_P    = 2084,
    parameter int MAX_P    = 2777,
    parameter int TIMEOUT  = 4546,
    parameter int RUN_NEED = 2,
    localparam int CW      = $clog2(TIMEOUT + 1),
    localparam int RW      = $clog2(RUN_NEED + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    output logic present_o
);
    logic [CW-1:0] gap_q;
    logic [RW-1:0] run_q;
    logic          present_q;
    meas_t         m;

    always_comb begin
        m.hit      = rise_i;
        m.in_win   = (gap_q >= CW'(MIN_P)) && (gap_q <= CW'(MAX_P));
        m.at_limit = (gap_q == CW'(TIMEOUT));
    end

    // Gap counter: cycles since the last rising edge, saturating
    always_ff @(posedge clk) begin
        if (rst)              gap_q <= CW'(TIMEOUT);
        else if (m.hit)       gap_q <= CW'(1);
        else if (!m.at_limit) gap_q <= gap_q + 1'b1;
    end

    // Run of consecutive good periods and the presence decision
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            present_q <= 1'b0;
        end else if (m.hit) begin
            if (m.in_win) begin
                if (run_q == RW'(RUN_NEED - 1)) present_q <= 1'b1;
                else                            run_q     <= run_q + 1'b1;
            end else begin
                run_q     <= '0;
                present_q <= 1'b0;
            end
        end else if (m.at_limit) begin
            run_q     <= '0;
            present_q <= 1'b0;
        end
    end

    assign present_o = present_q;

    // R7
    presence_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(present_q) |-> $past(rise_i && m.in_win))
        else $error("presence without a good period");

    // R9
    bad_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_i && !m.in_win) |=> !present_q)
        else $error("presence held after bad period");

    // R10
    timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (m.at_limit && !rise_i) |=> !present_q)
        else $error("presence held through silence");
endmodule

// File: rtl/tone22_gate.sv
module tone22_gate
    import tone22_pkg::*;
#(
    parameter int CLK_HZ         = 50_000_000,
    parameter int TONE_HZ        = 22_000,
    parameter int DET_LO_HZ      = 18_000,
    parameter int DET_HI_HZ      = 24_000,
    parameter int SYNC_STAGES    = 2,
    parameter int RUN_NEED       = 2,
    parameter int ABSENT_PERIODS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic tone_force_i,
    input  logic key_i,
    input  logic det_in_i,
    output logic tone_o,
    output logic det_n_o
);
    localparam int HALF    = half_cycles(CLK_HZ, TONE_HZ);
    localparam int NOM_P   = period_cycles(CLK_HZ, TONE_HZ);
    localparam int MIN_P   = ceil_div(CLK_HZ, DET_HI_HZ);
    localparam int MAX_P   = CLK_HZ / DET_LO_HZ;
    localparam int TIMEOUT = NOM_P * ABSENT_PERIODS;
    localparam int HCW     = $clog2(HALF + 1);

    logic [HCW-1:0] t_cnt;
    logic           t_done;
    logic           t_clr;
    logic           rise;
    logic           present;

    tone_half_timer #(.HALF(HALF)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (t_clr),
        .cnt_o  (t_cnt),
        .done_o (t_done)
    );

    tone_gate_fsm #(.HALF(HALF)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .force_i  (tone_force_i),
        .key_i    (key_i),
        .t_cnt_i  (t_cnt),
        .t_done_i (t_done),
        .t_clr_o  (t_clr),
        .tone_o   (tone_o)
    );

    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    (det_in_i),
        .rise_o (rise)
    );

    tone_detector #(
        .MIN_P    (MIN_P),
        .MAX_P    (MAX_P),
        .TIMEOUT  (TIMEOUT),
        .RUN_NEED (RUN_NEED)
    ) u_det (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise),
        .present_o (present)
    );

    assign det_n_o = ~present;

    // R1
    reset_out_chk: assert property (@(posedge clk)
        $past(rst) |-> (!tone_o && det_n_o))
        else $error("outputs not at reset value");
endmodule

// File: tb/tb_tone22_gate.sv
module tb_tone22_gate;
    localparam int CLK_HZ = 2_200_000;
    localparam int HALF   = 50;
    localparam int TO     = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_i = 1'b0, tone_force_i = 1'b0, key_i = 1'b0, det_in_i = 1'b0;
    logic tone_o, det_n_o;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        bit    is_det;
        bit    exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tone22_gate #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst(rst), .en_i(en_i), .tone_force_i(tone_force_i),
        .key_i(key_i), .det_in_i(det_in_i), .tone_o(tone_o), .det_n_o(det_n_o)
    );

    task automatic push(input int at, input bit is_det, input bit exp, input string tag);
        item_t it;
        it.at = at; it.is_det = is_det; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare every item due this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                logic act;
                act = sb[i].is_det ? det_n_o : tone_o;
                n_tests++;
                if (act !== sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s: %s at cycle %0d actual %0b expected %0b",
                             sb[i].tag, sb[i].is_det ? "det_n_o" : "tone_o",
                             cyc, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a receive train; the detector must be idle at entry
    task automatic train(input int period, input int nedges, input bit accept,
                         input bit tail, input string tag);
        int c, last;
        last = 0;
        for (int k = 1; k <= nedges; k++) begin
            @(negedge clk);
            c = cyc;
            det_in_i = 1'b1;
            if (k == 3 && accept) push(c + 2, 1, 1'b1, tag);
            if (k >= 3) push(c + 3, 1, !accept, tag);
            last = c;
            wait_n(period / 2);
            det_in_i = 1'b0;
            wait_n(period - period / 2 - 1);
        end
        if (accept && tail) begin
            push(last + 3 + TO - 1, 1, 1'b0, "R10 held before timeout");
            push(last + 3 + TO,     1, 1'b1, "R10 released on timeout");
        end
    endtask

    initial begin : driver
        int c, d;
        wait_n(3);
        push(cyc + 1, 0, 1'b0, "R1 tone reset");
        push(cyc + 1, 1, 1'b1, "R1 det reset");
        rst = 1'b0;
        wait_n(3);

        // R3 / R2 / R6: forced tone, key toggles ignored, then disable
        @(negedge clk); c = cyc;
        en_i = 1'b1; tone_force_i = 1'b1; key_i = 1'b0;
        push(c + 1,   0, 1'b1, "R3 start");
        push(c + 50,  0, 1'b1, "R2 high half end");
        push(c + 51,  0, 1'b0, "R2 low half start");
        push(c + 100, 0, 1'b0, "R2 low half end");
        push(c + 101, 0, 1'b1, "R3 second high");
        push(c + 150, 0, 1'b1, "R3 key ignored");
        push(c + 151, 0, 1'b0, "R3 key ignored");
        push(c + 201, 0, 1'b1, "R3 third high");
        wait_n(20);  key_i = 1'b1;
        wait_n(10);  key_i = 1'b0;
        wait_n(30);  key_i = 1'b1;
        wait_n(15);  key_i = 1'b0;
        wait_n(c + 210 - cyc);
        en_i = 1'b0;
        push(c + 211, 0, 1'b0, "R6 off next cycle");
        push(c + 260, 0, 1'b0, "R6 stays off");
        push(c + 300, 0, 1'b0, "R6 stays off");
        wait_n(100);
        tone_force_i = 1'b0; en_i = 1'b1;
        push(cyc + 2, 0, 1'b0, "R4 no key no tone");
        wait_n(10);

        // R4 / R5: keyed tone
        @(negedge clk); d = cyc;
        key_i = 1'b1;
        push(d + 1,   0, 1'b1, "R4 keyed start");
        push(d + 50,  0, 1'b1, "R4 high half");
        push(d + 51,  0, 1'b0, "R4 low half");
        push(d + 101, 0, 1'b1, "R4 second high");
        wait_n(d + 110 - cyc);
        key_i = 1'b0;
        push(d + 150, 0, 1'b1, "R5 high half completes");
        push(d + 151, 0, 1'b0, "R5 low after half");
        push(d + 201, 0, 1'b0, "R5 stays idle");
        push(d + 220, 0, 1'b0, "R5 stays idle");
        wait_n(d + 230 - cyc);
        key_i = 1'b1;
        push(d + 231, 0, 1'b1, "R4 restart");
        wait_n(d + 290 - cyc);
        key_i = 1'b0;
        push(d + 291, 0, 1'b0, "R5 drop in low half");
        push(d + 331, 0, 1'b0, "R5 no high after drop");
        wait_n(d + 350 - cyc);
        key_i = 1'b1;
        push(d + 351, 0, 1'b1, "R5 immediate restart");
        wait_n(1);
        key_i = 1'b0;
        push(d + 400, 0, 1'b1, "R5 full half after short key");
        push(d + 401, 0, 1'b0, "R5 end after short key");
        wait_n(60);

        // Detector
        train(100, 4, 1'b1, 1'b1, "R7 nominal tone");
        wait_n(TO + 20);
        train(92, 4, 1'b1, 1'b1, "R8 lower bound accepted");
        wait_n(TO + 20);
        train(122, 4, 1'b1, 1'b1, "R8 upper bound accepted");
        wait_n(TO + 20);
        train(91, 4, 1'b0, 1'b0, "R8 too fast rejected");
        wait_n(TO + 20);
        train(123, 4, 1'b0, 1'b0, "R8 too slow rejected");
        wait_n(TO + 20);

        // R9: presence dropped by a short period
        train(100, 3, 1'b1, 1'b0, "R9 setup");
        @(negedge clk); c = cyc;
        det_in_i = 1'b1;
        push(c + 3, 1, 1'b0, "R9 still present");
        wait_n(40); det_in_i = 1'b0;
        wait_n(39);
        @(negedge clk); c = cyc;
        det_in_i = 1'b1;
        push(c + 2, 1, 1'b0, "R9 before bad edge");
        push(c + 3, 1, 1'b1, "R9 released on bad period");
        wait_n(40); det_in_i = 1'b0;
        wait_n(TO + 20);

        if (sb.size() != 0) begin
            n_fail += sb.size();
            $display("FAIL scoreboard: %0d items never compared, expected 0", sb.size());
        end
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule